// File: doc/BRIEF.md
# Timestamp-Scheduled Transmit Burst Gate

This gate sits between a transmit sample FIFO and a DAC interface. Each burst in the FIFO starts with a three-word header. The header gives a start timestamp, the number of samples and a GPIO pattern. The gate reads the header and then holds the burst back until the running timestamp reaches the start time. At that edge it drives the pattern onto the GPIO outputs. It then streams the burst samples to the DAC with a valid strobe.

After the last sample the gate always sends a fixed run of zero I/Q samples, three by default, so that the DAC output falls back to zero. The start time can be compared in two ways. Fine mode uses the full timestamp. Coarse mode compares only the upper half, which is used as a seconds count. A burst whose start time has already passed is sent at once and raises a late flag. If the FIFO runs dry while a burst is streaming, the gate fills the gap with zero samples and raises a sticky underrun flag.

Top module: `tx_sched_gate`

## Requirements
- R1: A header is three FIFO words, read in this order. Word 0 holds the low 32 bits of the start time. Word 1 holds the high 32 bits. In word 2, bits [15:0] hold the sample count minus one, bits [23:16] hold the GPIO pattern, and bit 31 is the coarse-mode select. Header words may arrive with empty gaps between them.
- R2: In fine mode (bit 31 = 0), `gpioOut` takes the pattern on the first clock edge at which the sampled `tsNow` is at or above the start time. The first burst sample appears at the outputs on the following edge.
- R3: In coarse mode (bit 31 = 1), only `tsNow[63:32]` is compared against the header's high word, and the low word is ignored.
- R4: Burst samples leave in FIFO order with `dacValid` high. I is taken from word bits [31:16] and Q from bits [15:0]. Exactly count+1 samples are sent.
- R5: Exactly three zero I/Q samples with `dacValid` high follow the last burst sample. After them `dacValid` falls.
- R6: While the gate is idle, reading a header or waiting for the start time, `dacValid` is low and `dacI` and `dacQ` are zero.
- R7: `lateFlag` is updated each time a burst fires. It becomes 1 when the start time was strictly earlier than `tsNow` on the first wait cycle, in which case the burst fires at once. Otherwise it becomes 0. It then holds until the next burst fires.
- R8: If the FIFO is empty during streaming, the gate sends zero samples with `dacValid` high and does not advance the burst. In that case `underrunFlag` is set and stays set until reset.
- R9: `gpioOut` holds its pattern between triggers. It changes only when a burst fires.
- R10: `fifoRd` is asserted only while `fifoEmpty` is low. Each assertion consumes one word.
- R11: After reset, `gpioOut`, `lateFlag`, `underrunFlag` and `dacValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifoData | input | 32 | Show-ahead FIFO head word |
| fifoEmpty | input | 1 | FIFO has no word |
| fifoRd | output | 1 | Pop the head word this cycle |
| tsNow | input | 64 | Running timestamp |
| dacI | output | 16 | In-phase sample |
| dacQ | output | 16 | Quadrature sample |
| dacValid | output | 1 | Sample strobe |
| gpioOut | output | 8 | Trigger pattern outputs |
| lateFlag | output | 1 | Last burst started late |
| underrunFlag | output | 1 | Sticky FIFO underrun |

## Verification
The bench measures the exact timestamp at which the first sample appears. A gate that is off by one in its compare, or that adds a stage between the trigger and the sample, fails this check. Coarse mode is tested with a start time whose low word lies far in the future of the current low word. A gate that compared the full value would never fire or would fire late. A late burst and an underrun in the middle of a burst are also exercised. A gate that dropped words, counted underrun zeros as burst samples, shortened the zero flush or cleared the sticky flag would produce the wrong sample sequence or wrong flag values.

// File: rtl/txgate_pkg.sv
package txgate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WAIT,
    ST_STREAM,
    ST_FLUSH
  } gateState_t;

  typedef struct packed {
    logic [2:0] hdrWe;     // load header word 0/1/2
    logic       fire;      // trigger: apply pattern, update late status
    logic       firstWait; // first cycle spent waiting for this burst
    logic       sendData;  // present the FIFO head word as a sample
    logic       sendZero;  // present a zero sample with valid high
  } gateCtl_t;
endpackage

// File: rtl/txgate_datapath.sv
module txgate_datapath
  import txgate_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LEN_W    = 16,
  parameter int GPIO_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  gateCtl_t              ctl,
  input  logic [2*SAMPLE_W-1:0] fifoData,
  input  logic [4*SAMPLE_W-1:0] tsNow,
  output logic                  due,
  output logic [LEN_W-1:0]      hdrLen,
  output logic [SAMPLE_W-1:0]   dacI,
  output logic [SAMPLE_W-1:0]   dacQ,
  output logic                  dacValid,
  output logic [GPIO_W-1:0]     gpioOut,
  output logic                  lateFlag
);
  localparam int WORD_W     = 2 * SAMPLE_W;
  localparam int TS_W       = 2 * WORD_W;
  localparam int PAT_LSB    = LEN_W;
  localparam int COARSE_BIT = WORD_W - 1;

  logic [WORD_W-1:0] startLo, startHi;
  logic [GPIO_W-1:0] patQ;
  logic              coarseQ;
  logic [LEN_W-1:0]  lenQ;
  logic              isPast;
  logic [WORD_W-1:0] nowHi;
  logic [TS_W-1:0]   startFull;

  assign nowHi     = tsNow[TS_W-1:WORD_W];
  assign startFull = {startHi, startLo};
  assign hdrLen    = lenQ;

  // Header capture
  always_ff @(posedge clk) begin
    if (rst) begin
      startLo <= '0;
      startHi <= '0;
      lenQ    <= '0;
      patQ    <= '0;
      coarseQ <= 1'b0;
    end else begin
      if (ctl.hdrWe[0]) startLo <= fifoData;
      if (ctl.hdrWe[1]) startHi <= fifoData;
      if (ctl.hdrWe[2]) begin
        lenQ    <= fifoData[LEN_W-1:0];
        patQ    <= fifoData[PAT_LSB+GPIO_W-1:PAT_LSB];
        coarseQ <= fifoData[COARSE_BIT];
      end
    end
  end

  // Start-time comparison, full value or upper half only
  always_comb begin
    if (coarseQ) begin
      due    = (nowHi >= startHi);
      isPast = (nowHi > startHi);
    end else begin
      due    = (tsNow >= startFull);
      isPast = (tsNow > startFull);
    end
  end

  // Trigger outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      gpioOut  <= '0;
      lateFlag <= 1'b0;
    end else if (ctl.fire) begin
      gpioOut  <= patQ;
      lateFlag <= ctl.firstWait && isPast;
    end
  end

  // Sample outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      dacI     <= '0;
      dacQ     <= '0;
      dacValid <= 1'b0;
    end else if (ctl.sendData) begin
      dacI     <= fifoData[WORD_W-1:SAMPLE_W];
      dacQ     <= fifoData[SAMPLE_W-1:0];
      dacValid <= 1'b1;
    end else begin
      dacI     <= '0;
      dacQ     <= '0;
      dacValid <= ctl.sendZero;
    end
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dacValid |-> (dacI == '0 && dacQ == '0));

  // R9
  gpio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl.fire) |-> $stable(gpioOut));

  // R7
  late_only_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lateFlag) |-> $past(ctl.fire));
endmodule

// File: rtl/txgate_control.sv
module txgate_control
  import txgate_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int FLUSH_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifoEmpty,
  input  logic             due,
  input  logic [LEN_W-1:0] hdrLen,
  output logic             fifoRd,
  output gateCtl_t         ctl,
  output logic             underrun
);
  localparam int FL_W = $clog2(FLUSH_LEN + 1);
  localparam logic [FL_W-1:0] FL_LAST = FL_W'(FLUSH_LEN - 1);

  gateState_t       state, nextState;
  logic [1:0]       hdrIdx;
  logic [LEN_W-1:0] remain;
  logic [FL_W-1:0]  flushCnt;
  logic             firstWaitQ;

  always_comb begin
    nextState = state;
    ctl       = '0;
    fifoRd    = 1'b0;
    case (state)
      ST_IDLE: if (!fifoEmpty) nextState = ST_HDR;
      ST_HDR: begin
        if (!fifoEmpty) begin
          fifoRd = 1'b1;
          case (hdrIdx)
            2'd0:    ctl.hdrWe = 3'b001;
            2'd1:    ctl.hdrWe = 3'b010;
            default: ctl.hdrWe = 3'b100;
          endcase
          if (hdrIdx == 2'd2) nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctl.firstWait = firstWaitQ;
        if (due) begin
          ctl.fire  = 1'b1;
          nextState = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (!fifoEmpty) begin
          fifoRd       = 1'b1;
          ctl.sendData = 1'b1;
          if (remain == '0) nextState = ST_FLUSH;
        end else begin
          ctl.sendZero = 1'b1;
        end
      end
      ST_FLUSH: begin
        ctl.sendZero = 1'b1;
        if (flushCnt == FL_LAST) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hdrIdx     <= '0;
      remain     <= '0;
      flushCnt   <= '0;
      firstWaitQ <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      state      <= nextState;
      firstWaitQ <= (state != ST_WAIT) && (nextState == ST_WAIT);
      if (ctl.hdrWe != '0) hdrIdx <= (hdrIdx == 2'd2) ? 2'd0 : hdrIdx + 2'd1;
      if (ctl.fire) remain <= hdrLen;
      else if (ctl.sendData && remain != '0) remain <= remain - 1'b1;
      if (state == ST_FLUSH) flushCnt <= flushCnt + 1'b1;
      else flushCnt <= '0;
      if (state == ST_STREAM && fifoEmpty) underrun <= 1'b1;
    end
  end

  // R10
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    fifoRd |-> !fifoEmpty);

  // R8
  sticky_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    $past(underrun) |-> underrun);

  // R5
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH) |-> (flushCnt < FL_W'(FLUSH_LEN)));

  // R5
  flush_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STREAM && ctl.sendData && remain == '0) |=> (state == ST_FLUSH));
endmodule

// File: rtl/tx_sched_gate.sv
module tx_sched_gate
  import txgate_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LEN_W     = 16,
  parameter int GPIO_W    = 8,
  parameter int FLUSH_LEN = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*SAMPLE_W-1:0] fifoData,
  input  logic                  fifoEmpty,
  output logic                  fifoRd,
  input  logic [4*SAMPLE_W-1:0] tsNow,
  output logic [SAMPLE_W-1:0]   dacI,
  output logic [SAMPLE_W-1:0]   dacQ,
  output logic                  dacValid,
  output logic [GPIO_W-1:0]     gpioOut,
  output logic                  lateFlag,
  output logic                  underrunFlag
);
  gateCtl_t         ctl;
  logic             due;
  logic [LEN_W-1:0] hdrLen;

  txgate_control #(.LEN_W(LEN_W), .FLUSH_LEN(FLUSH_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .due(due), .hdrLen(hdrLen),
    .fifoRd(fifoRd), .ctl(ctl), .underrun(underrunFlag)
  );

  txgate_datapath #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .GPIO_W(GPIO_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .fifoData(fifoData), .tsNow(tsNow),
    .due(due), .hdrLen(hdrLen), .dacI(dacI), .dacQ(dacQ), .dacValid(dacValid),
    .gpioOut(gpioOut), .lateFlag(lateFlag)
  );
endmodule

// File: tb/tb_tx_sched_gate.sv
`timescale 1ns/1ps
module tb_tx_sched_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoRd;
  logic [63:0] ts = 64'd0;
  logic [15:0] dacI, dacQ;
  logic        dacValid;
  logic [7:0]  gpioOut;
  logic        lateFlag, underrunFlag;

  always #4 clk = ~clk;  // 125 MHz

  // Bench FIFO, show-ahead
  logic [31:0] fifoMem [0:255];
  logic [7:0]  wptr = 8'd0;
  logic [7:0]  rptr = 8'd0;
  assign fifoData  = fifoMem[rptr];
  assign fifoEmpty = (rptr == wptr);
  always @(posedge clk) if (fifoRd && !fifoEmpty) rptr <= rptr + 8'd1;

  // Running timestamp with jump control
  logic        tsSet = 1'b0;
  logic [63:0] tsVal = 64'd0;
  always @(posedge clk) ts <= tsSet ? tsVal : ts + 64'd1;

  tx_sched_gate dut (
    .clk(clk), .rst(rst), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoRd(fifoRd), .tsNow(ts), .dacI(dacI), .dacQ(dacQ), .dacValid(dacValid),
    .gpioOut(gpioOut), .lateFlag(lateFlag), .underrunFlag(underrunFlag)
  );

  // Output capture
  logic [31:0] capQ[$];
  logic [63:0] firstTsQ[$];
  logic        prevValid = 1'b0;
  always @(negedge clk) begin
    if (!rst && dacValid) begin
      capQ.push_back({dacI, dacQ});
      if (!prevValid) firstTsQ.push_back(ts);
    end
    prevValid = dacValid;
  end

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    fifoMem[wptr] = w;
    wptr = wptr + 8'd1;
  endtask

  task automatic pushHeader(input logic [63:0] start, input logic [7:0] pat,
                            input logic coarse, input logic [15:0] cntM1);
    pushWord(start[31:0]);
    pushWord(start[63:32]);
    pushWord({coarse, 7'd0, pat, cntM1});
  endtask

  task automatic jumpTs(input logic [63:0] v);
    @(negedge clk); tsSet = 1'b1; tsVal = v;
    @(negedge clk); tsSet = 1'b0;
  endtask

  task automatic waitCap(input int n);
    int t = 0;
    while (capQ.size() < n && t < 3000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] smp(input int b, input int k);
    return {16'(16'h1000 + b * 16'h100 + k), 16'(16'h2000 + b * 16'h100 + k)};
  endfunction

  task automatic testReset();
    check(gpioOut == 8'h00, "R11 gpio", 64'(gpioOut), 0);
    check(lateFlag == 1'b0, "R11 late", 64'(lateFlag), 0);
    check(underrunFlag == 1'b0, "R11 underrun", 64'(underrunFlag), 0);
    check(dacValid == 1'b0, "R11 valid", 64'(dacValid), 0);
    check(fifoRd == 1'b0, "R10 no pop when empty", 64'(fifoRd), 0);
  endtask

  task automatic testFineOnTime();
    capQ.delete(); firstTsQ.delete();
    jumpTs(64'd100);
    // R1: header words with gaps between them
    pushWord(32'd140);
    repeat (3) @(negedge clk);
    pushWord(32'd0);
    repeat (2) @(negedge clk);
    pushWord({1'b0, 7'd0, 8'hA5, 16'd3});
    for (int k = 0; k < 4; k++) pushWord(smp(1, k));
    while (ts < 64'd130) @(negedge clk);
    check(dacValid == 1'b0 && dacI == 0 && dacQ == 0, "R6 zero while waiting", {dacI, dacQ, 31'd0, dacValid}, 0);
    check(gpioOut == 8'h00, "R9 gpio held before trigger", 64'(gpioOut), 0);
    waitCap(7);
    check(gpioOut == 8'hA5, "R2 pattern applied", 64'(gpioOut), 64'hA5);
    check(firstTsQ.size() == 1 && firstTsQ[0] == 64'd142, "R2 first sample time",
          firstTsQ.size() > 0 ? firstTsQ[0] : 64'hdead, 64'd142);
    check(capQ.size() == 7, "R5 sample count with flush", 64'(capQ.size()), 7);
    for (int k = 0; k < 4; k++)
      if (k < capQ.size()) check(capQ[k] == smp(1, k), "R4 sample order", 64'(capQ[k]), 64'(smp(1, k)));
    for (int k = 4; k < 7; k++)
      if (k < capQ.size()) check(capQ[k] == 32'd0, "R5 zero flush", 64'(capQ[k]), 0);
    check(lateFlag == 1'b0, "R7 on-time not late", 64'(lateFlag), 0);
    check(underrunFlag == 1'b0, "R8 no underrun", 64'(underrunFlag), 0);
  endtask

  task automatic testCoarse();
    capQ.delete(); firstTsQ.delete();
    jumpTs({32'd5, 32'hFFFF_FFE0});
    pushHeader({32'd6, 32'h7000_0000}, 8'h3C, 1'b1, 16'd1);
    pushWord(smp(2, 0));
    pushWord(smp(2, 1));
    waitCap(5);
    check(firstTsQ.size() == 1 && firstTsQ[0] == {32'd6, 32'd2}, "R3 coarse trigger time",
          firstTsQ.size() > 0 ? firstTsQ[0] : 64'hdead, {32'd6, 32'd2});
    check(gpioOut == 8'h3C, "R3 coarse pattern", 64'(gpioOut), 64'h3C);
    check(capQ.size() == 5, "R4 coarse count", 64'(capQ.size()), 5);
  endtask

  task automatic testLate();
    capQ.delete(); firstTsQ.delete();
    jumpTs(64'd5000);
    check(gpioOut == 8'h3C, "R9 gpio holds between bursts", 64'(gpioOut), 64'h3C);
    pushHeader(64'd1000, 8'h0F, 1'b0, 16'd0);
    pushWord(smp(3, 0));
    waitCap(4);
    check(lateFlag == 1'b1, "R7 late flagged", 64'(lateFlag), 1);
    check(gpioOut == 8'h0F, "R7 late pattern", 64'(gpioOut), 64'h0F);
    check(capQ.size() == 4 && capQ[0] == smp(3, 0), "R7 late burst sent",
          capQ.size() > 0 ? 64'(capQ[0]) : 64'hdead, 64'(smp(3, 0)));
  endtask

  task automatic testUnderrun();
    int n;
    logic between;
    capQ.delete(); firstTsQ.delete();
    pushHeader(ts + 64'd40, 8'h81, 1'b0, 16'd3);
    pushWord(smp(4, 0));
    pushWord(smp(4, 1));
    while (capQ.size() < 4) @(negedge clk);
    pushWord(smp(4, 2));
    pushWord(smp(4, 3));
    waitCap(9);
    n = capQ.size();
    check(n >= 8, "R8 length", 64'(n), 8);
    if (n >= 8) begin
      check(capQ[0] == smp(4, 0) && capQ[1] == smp(4, 1), "R8 head samples", 64'(capQ[1]), 64'(smp(4, 1)));
      check(capQ[n-5] == smp(4, 2) && capQ[n-4] == smp(4, 3), "R8 resumed samples", 64'(capQ[n-4]), 64'(smp(4, 3)));
      between = 1'b1;
      for (int k = 2; k < n - 5; k++) if (capQ[k] != 0) between = 1'b0;
      check(between && n - 7 >= 1, "R8 zero fill", 64'(n), 9);
      check(capQ[n-3] == 0 && capQ[n-2] == 0 && capQ[n-1] == 0, "R5 flush after underrun", 64'(capQ[n-1]), 0);
    end
    check(underrunFlag == 1'b1, "R8 underrun flag", 64'(underrunFlag), 1);
    check(lateFlag == 1'b0, "R7 late cleared on next fire", 64'(lateFlag), 0);
    repeat (20) @(negedge clk);
    check(underrunFlag == 1'b1, "R8 sticky", 64'(underrunFlag), 1);
    check(dacValid == 1'b0, "R6 idle after burst", 64'(dacValid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testFineOnTime();
    testCoarse();
    testLate();
    testUnderrun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule